// File: doc/BRIEF.md
# Seconds-Count Real-Time Clock Register Block

This block is the register side of a real-time clock. A 32-bit seconds count advances by one on each pulse of an external one-second tick while counting is switched on. The block also holds a 32-bit alarm compare value, a control and status word, a trim word, a scratch word and a power-down request port. It sits on a simple synchronous register bus. Reads return combinationally from the addressed register. A write takes effect on the clock edge where it is presented.

Each accepted write is followed by a fixed busy window, during which the block ignores further writes. Software polls the ready bit in the control word before it writes. Two sticky event flags, one for the per-second tick and one for the alarm, drive a level interrupt through their own enables. Software clears a flag by writing 0 to its bit. Writing 1 to the bit leaves the flag as it is.

Top module: `rtc_secs_periph`

## Requirements
- R1: After reset, the control word reads 0x00000080 (ready high). The seconds, alarm, trim and scratch registers read 0. `irq` and `hib_req` are low.
- R2: While the control bit 0 (run) is 1, each cycle with `tick_1hz` high adds 1 to the seconds register at offset 0x04, and 0xFFFFFFFF wraps to 0. While run is 0, ticks leave the count unchanged.
- R3: An accepted write drives control bit 7 (ready) low for BUSY_CYC cycles (default 4), then ready returns high. A write presented while ready is low changes no register.
- R4: A control write with 0 in bit 6 clears the per-second flag, and 0 in bit 4 clears the alarm flag. A 1 in either bit leaves that flag unchanged.
- R5: Every counting tick (run = 1, no seconds write in the same cycle) sets the per-second flag, bit 6.
- R6: The alarm flag (bit 4) sets on a counting tick whose incremented count equals the alarm register at offset 0x08, but only when control bit 2 (alarm enable) is 1.
- R7: `irq` is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of the control word are both set.
- R8: Software can write the seconds register directly. A write and a tick in the same cycle load the written value, and the tick is dropped.
- R9: A write to offset 0x20 with data bit 0 = 1 raises `hib_req` for exactly one cycle. Offset 0x20 reads 0.
- R10: The trim word (0x0C) and the scratch word (0x34) keep the last accepted value written to them.
- R11: When a tick sets a flag in the same cycle that a control write clears it, the flag ends up set.
- R12: Control bits 5, 3, 2 and 0 are read/write. Bits 7, 6 and 4 cannot be set by a write. Bits 1 and 31..8 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse each second |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |
| hib_req | output | 1 | One-cycle power-down request |

## Verification
Some cases are hard to reach from the ports because they need a tick and a bus write to land on the same clock edge. These are a seconds load that collides with a tick, and a flag clear that collides with the flag being set. The stimulus first waits for ready by polling. It then presents the write and raises the tick in the same cycle, so the collision lands on one known edge. A second write issued right after an accepted one falls inside the busy window. A long random phase mixes ticks with unpaced writes to every offset, and a per-cycle behavioural model checks the result.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned REG_AW = 6;

    typedef logic [REG_AW-1:0] reg_addr_t;
    typedef logic [DW-1:0]     word_t;

    localparam reg_addr_t OFS_CTRL    = 6'h00;
    localparam reg_addr_t OFS_SECS    = 6'h04;
    localparam reg_addr_t OFS_ALARM   = 6'h08;
    localparam reg_addr_t OFS_TRIM    = 6'h0C;
    localparam reg_addr_t OFS_HIB     = 6'h20;
    localparam reg_addr_t OFS_SCRATCH = 6'h34;

    localparam int unsigned B_RDY  = 7;
    localparam int unsigned B_HZF  = 6;
    localparam int unsigned B_HZIE = 5;
    localparam int unsigned B_ALF  = 4;
    localparam int unsigned B_ALIE = 3;
    localparam int unsigned B_ALEN = 2;
    localparam int unsigned B_RUN  = 0;

    typedef struct packed {
        logic hz_ie;
        logic al_ie;
        logic al_en;
        logic run;
    } rtc_cfg_t;

    typedef struct packed {
        logic hz;
        logic al;
    } rtc_flags_t;

    function automatic rtc_cfg_t cfg_from_word(input word_t w);
        rtc_cfg_t c;
        c.hz_ie = w[B_HZIE];
        c.al_ie = w[B_ALIE];
        c.al_en = w[B_ALEN];
        c.run   = w[B_RUN];
        return c;
    endfunction

    function automatic word_t ctrl_word(input logic rdy, input rtc_flags_t f,
                                        input rtc_cfg_t c);
        word_t w;
        w         = '0;
        w[B_RDY]  = rdy;
        w[B_HZF]  = f.hz;
        w[B_HZIE] = c.hz_ie;
        w[B_ALF]  = f.al;
        w[B_ALIE] = c.al_ie;
        w[B_ALEN] = c.al_en;
        w[B_RUN]  = c.run;
        return w;
    endfunction

endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
    parameter int unsigned BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    output logic wr_ok,
    output logic wr_rdy
);
    localparam int unsigned CW = (BUSY_CYC < 1) ? 1 : $clog2(BUSY_CYC + 1);

    generate
        if (BUSY_CYC == 0) begin : g_free
            assign wr_rdy = 1'b1;
        end else begin : g_hold
            localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q <= '0;
                end else if (wr_req && (cnt_q == '0)) begin
                    cnt_q <= LOAD;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign wr_rdy = (cnt_q == '0);
        end
    endgenerate

    assign wr_ok = wr_req & wr_rdy;
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  run,
    input  logic  load,
    input  word_t load_val,
    input  word_t alarm_val,
    input  logic  alarm_en,
    output word_t secs,
    output logic  step,
    output logic  match
);
    word_t cnt_q;
    word_t nxt;

    assign nxt   = cnt_q + 1'b1;
    assign step  = tick & run & ~load;
    assign match = step & alarm_en & (nxt == alarm_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= nxt;
        end
    end

    assign secs = cnt_q;
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hz_set,
    input  logic       al_set,
    input  logic       clr_en,
    input  logic       keep_hz,
    input  logic       keep_al,
    input  rtc_cfg_t   cfg,
    output rtc_flags_t flags,
    output logic       irq
);
    rtc_flags_t flg_q;
    rtc_flags_t flg_d;

    always_comb begin
        flg_d = flg_q;
        if (clr_en && !keep_hz) flg_d.hz = 1'b0;
        if (clr_en && !keep_al) flg_d.al = 1'b0;
        if (hz_set)             flg_d.hz = 1'b1;
        if (al_set)             flg_d.al = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '0;
        else     flg_q <= flg_d;
    end

    assign flags = flg_q;
    assign irq   = (flg_q.hz & cfg.hz_ie) | (flg_q.al & cfg.al_ie);
endmodule

// File: rtl/rtc_secs_periph.sv
module rtc_secs_periph
    import rtc_pkg::*;
#(
    parameter int unsigned BUSY_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_1hz,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        hib_req
);
    logic       wr_ok, wr_rdy;
    logic       wr_ctrl, sec_load, wr_alarm, wr_trim, wr_scr, wr_hib;
    logic       step, match;
    word_t      secs;
    word_t      alarm_q, trim_q, scr_q;
    rtc_cfg_t   cfg_q;
    rtc_flags_t flags;
    logic       hib_q;

    rtc_wr_gate #(.BUSY_CYC(BUSY_CYC)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .wr_req (bus_sel & bus_we),
        .wr_ok  (wr_ok),
        .wr_rdy (wr_rdy)
    );

    assign wr_ctrl  = wr_ok && (bus_addr == OFS_CTRL);
    assign sec_load = wr_ok && (bus_addr == OFS_SECS);
    assign wr_alarm = wr_ok && (bus_addr == OFS_ALARM);
    assign wr_trim  = wr_ok && (bus_addr == OFS_TRIM);
    assign wr_scr   = wr_ok && (bus_addr == OFS_SCRATCH);
    assign wr_hib   = wr_ok && (bus_addr == OFS_HIB);

    rtc_sec_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_1hz),
        .run       (cfg_q.run),
        .load      (sec_load),
        .load_val  (bus_wdata),
        .alarm_val (alarm_q),
        .alarm_en  (cfg_q.al_en),
        .secs      (secs),
        .step      (step),
        .match     (match)
    );

    rtc_flag_unit u_flags (
        .clk     (clk),
        .rst     (rst),
        .hz_set  (step),
        .al_set  (match),
        .clr_en  (wr_ctrl),
        .keep_hz (bus_wdata[B_HZF]),
        .keep_al (bus_wdata[B_ALF]),
        .cfg     (cfg_q),
        .flags   (flags),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            alarm_q <= '0;
            trim_q  <= '0;
            scr_q   <= '0;
            hib_q   <= 1'b0;
        end else begin
            if (wr_ctrl)  cfg_q   <= cfg_from_word(bus_wdata);
            if (wr_alarm) alarm_q <= bus_wdata;
            if (wr_trim)  trim_q  <= bus_wdata;
            if (wr_scr)   scr_q   <= bus_wdata;
            hib_q <= wr_hib & bus_wdata[0];
        end
    end

    assign hib_req = hib_q;

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL:    bus_rdata = ctrl_word(wr_rdy, flags, cfg_q);
            OFS_SECS:    bus_rdata = secs;
            OFS_ALARM:   bus_rdata = alarm_q;
            OFS_TRIM:    bus_rdata = trim_q;
            OFS_SCRATCH: bus_rdata = scr_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_secs_chk.sv
module rtc_secs_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_ok,
    input logic        wr_rdy,
    input logic        step,
    input logic        sec_load,
    input logic        wr_ctrl,
    input logic [31:0] secs,
    input logic        hz_flag,
    input logic        al_flag,
    input logic        hz_ie,
    input logic        al_ie,
    input logic        irq,
    input logic        hib_req
);
    AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> !wr_rdy); // R3

    AST_SECS_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (secs == $past(secs) + 32'd1)); // R2

    AST_SECS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !sec_load) |=> $stable(secs)); // R2

    AST_HZ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (hz_flag && !wr_ctrl) |=> hz_flag); // R4

    AST_AL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (al_flag && !wr_ctrl) |=> al_flag); // R4

    AST_HZ_SET: assert property (@(posedge clk) disable iff (rst)
        step |=> hz_flag); // R11

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!(hz_flag && hz_ie) && !(al_flag && al_ie)) |-> !irq); // R7

    AST_HIB_PULSE: assert property (@(posedge clk) disable iff (rst)
        hib_req |=> !hib_req); // R9
endmodule

bind rtc_secs_periph rtc_secs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .wr_rdy   (wr_rdy),
    .step     (step),
    .sec_load (sec_load),
    .wr_ctrl  (wr_ctrl),
    .secs     (secs),
    .hz_flag  (flags.hz),
    .al_flag  (flags.al),
    .hz_ie    (cfg_q.hz_ie),
    .al_ie    (cfg_q.al_ie),
    .irq      (irq),
    .hib_req  (hib_req)
);

// File: tb/rtc_secs_periph_test.sv
`timescale 1ns/1ps
module rtc_secs_periph_test;
    localparam int BUSY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, hib_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_secs_periph #(.BUSY_CYC(BUSY)) uut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .hib_req(hib_req)
    );

    // behavioural reference model
    int          m_busy;
    logic [31:0] m_secs, m_alarm, m_trim, m_scr;
    logic        m_hzf, m_alf, m_hzie, m_alie, m_alen, m_run, m_hib;

    function automatic logic [31:0] m_read(input logic [5:0] a);
        case (a)
            6'h00: return {24'd0, (m_busy == 0), m_hzf, m_hzie, m_alf,
                           m_alie, m_alen, 1'b0, m_run};
            6'h04: return m_secs;
            6'h08: return m_alarm;
            6'h0C: return m_trim;
            6'h34: return m_scr;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_secs = 0; m_alarm = 0; m_trim = 0; m_scr = 0;
            m_hzf = 0; m_alf = 0; m_hzie = 0; m_alie = 0; m_alen = 0;
            m_run = 0; m_hib = 0;
        end else begin
            bit acc;
            logic [31:0] nsec, old_alarm;
            logic old_run, old_alen, nhz, nal;
            acc = bus_sel && bus_we && (m_busy == 0);
            old_run = m_run; old_alen = m_alen; old_alarm = m_alarm;
            nsec = m_secs; nhz = m_hzf; nal = m_alf;
            m_hib = acc && (bus_addr == 6'h20) && bus_wdata[0];
            if (acc && bus_addr == 6'h00) begin
                if (!bus_wdata[6]) nhz = 0;
                if (!bus_wdata[4]) nal = 0;
                m_hzie = bus_wdata[5]; m_alie = bus_wdata[3];
                m_alen = bus_wdata[2]; m_run = bus_wdata[0];
            end
            if (acc && bus_addr == 6'h04) nsec = bus_wdata;
            else if (tick_1hz && old_run) begin
                nsec = m_secs + 32'd1;
                nhz = 1;
                if (old_alen && nsec == old_alarm) nal = 1;
            end
            if (acc && bus_addr == 6'h08) m_alarm = bus_wdata;
            if (acc && bus_addr == 6'h0C) m_trim = bus_wdata;
            if (acc && bus_addr == 6'h34) m_scr = bus_wdata;
            m_secs = nsec; m_hzf = nhz; m_alf = nal;
            if (acc) m_busy = BUSY;
            else if (m_busy > 0) m_busy = m_busy - 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            string t;
            t = (bus_addr == 6'h00) ? "R4" : (bus_addr == 6'h04) ? "R2" : "R10";
            chk(t, bus_rdata, m_read(bus_addr));
            chk("R7", {31'd0, irq}, {31'd0, (m_hzf & m_hzie) | (m_alf & m_alie)});
            chk("R9", {31'd0, hib_req}, {31'd0, m_hib});
        end
    end

    task automatic wr_now(input logic [5:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; tick_1hz = t;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; tick_1hz = 0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bus_sel = 0; bus_addr = 6'h00;
            #1;
            if (bus_rdata[7]) break;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wait_ready();
        wr_now(a, d, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1;
            @(negedge clk); tick_1hz = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd("R1", 6'h00, 32'h80);
        rd("R1", 6'h04, 32'h0);
        rd("R1", 6'h34, 32'h0);
        chk("R1", {30'd0, irq, hib_req}, 32'h0);
        // R2 / R5 counting
        wr(6'h00, 32'h01);
        ticks(3);
        rd("R2", 6'h04, 32'd3);
        rd("R5", 6'h00, 32'hC1);
        // R3 busy window
        wr(6'h34, 32'hA5A5A5A5);
        wr_now(6'h34, 32'h1, 1'b0);
        rd("R3", 6'h00, 32'h41);
        rd("R3", 6'h34, 32'hA5A5A5A5);
        rd("R3", 6'h00, 32'hC1);
        // R4 write-one keeps, write-zero clears
        wr(6'h00, 32'h41);
        rd("R4", 6'h00, 32'h41);
        wr(6'h00, 32'h01);
        rd("R4", 6'h00, 32'h01);
        // R7 interrupt gating
        wr(6'h00, 32'h21);
        #1 chk("R7", {31'd0, irq}, 32'd0);
        ticks(1);
        #1 chk("R7", {31'd0, irq}, 32'd1);
        wr(6'h00, 32'h41);
        #1 chk("R7", {31'd0, irq}, 32'd0);
        rd("R7", 6'h00, 32'h41);
        // R6 alarm match
        wr(6'h04, 32'd9);
        wr(6'h08, 32'd11);
        wr(6'h00, 32'h0D);
        ticks(1);
        #1 chk("R6", {31'd0, irq}, 32'd0);
        ticks(1);
        #1 chk("R6", {31'd0, irq}, 32'd1);
        rd("R6", 6'h00, 32'hDD);
        wr(6'h00, 32'h01);
        wr(6'h04, 32'd20);
        wr(6'h08, 32'd21);
        ticks(1);
        rd("R6", 6'h00, 32'h41);
        // R2 wrap and hold
        wr(6'h04, 32'hFFFFFFFF);
        ticks(1);
        rd("R2", 6'h04, 32'h0);
        wr(6'h00, 32'h40);
        ticks(2);
        rd("R2", 6'h04, 32'h0);
        // R8 write beats tick
        wr(6'h00, 32'h01);
        wait_ready();
        wr_now(6'h04, 32'd100, 1'b1);
        rd("R8", 6'h04, 32'd100);
        // R11 set beats clear
        wr(6'h00, 32'h01);
        wait_ready();
        wr_now(6'h00, 32'h01, 1'b1);
        rd("R11", 6'h00, 32'h41);
        // R9 hibernate pulse
        wr(6'h20, 32'h1);
        #1 chk("R9", {31'd0, hib_req}, 32'd1);
        @(negedge clk); #1 chk("R9", {31'd0, hib_req}, 32'd0);
        rd("R9", 6'h20, 32'h0);
        // R12 writable bits
        wr(6'h00, 32'hFF);
        rd("R12", 6'h00, 32'h6D);
        // R10 retained words
        wr(6'h0C, 32'h12345678);
        rd("R10", 6'h0C, 32'h12345678);
        rd("R10", 6'h34, 32'hA5A5A5A5);
        wr(6'h00, 32'h0);
        // random mix, model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] al [7];
            al = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h20, 6'h34, 6'h10};
            @(negedge clk);
            bus_sel   = ($urandom_range(0, 3) == 0);
            bus_we    = $urandom_range(0, 1);
            bus_addr  = al[$urandom_range(0, 6)];
            bus_wdata = $urandom;
            if (bus_addr == 6'h04 || bus_addr == 6'h08) bus_wdata = {28'd0, bus_wdata[3:0]};
            tick_1hz  = ($urandom_range(0, 5) == 0);
        end
        @(negedge clk);
        bus_sel = 0; bus_we = 0; tick_1hz = 0;
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule